// File: doc/BRIEF.md
# LCD Drive Polarity Inversion Controller

This block produces the single polarity level that an LCD panel uses to alternate its drive voltage and avoid DC build-up on the liquid crystal. It follows the video line count and the field sync from a separate timing generator. It changes its output only when the timing generator strobes the back porch of a line, so a polarity change never falls inside visible pixels.

Two static inputs shape the output. The inversion-mode input picks between two behaviours. Pixel inversion, for normal video, flips the polarity on every line of the active window. Column inversion, for paused, cued or noisy video, holds one polarity for the whole window. The rate input picks how often the per-field base polarity alternates: every field, or every second field. That gives half or a quarter of the vertical rate, and the rate setting works the same way in both modes.

An internal 2-bit field counter starts at zero on reset and advances on every field sync. In fields where this counter is even, one extra polarity change happens at line 4. Which physical field gets that extra change therefore depends on the moment the counter was last reset.

Top module: `lcd_pol_inv`

## Requirements
- R1: While reset is active and in the first cycle after it, `pol` is 0. The internal base polarity and field counter are also cleared.
- R2: A back-porch strobe on a line outside lines 22 to 261 leaves `pol` unchanged, unless the line is 4 and the field counter is even.
- R3: In a cycle without a back-porch strobe, `pol` does not change, whatever the line number, field sync or select inputs do.
- R4: A back-porch strobe on line 22 sets `pol` to the current base polarity in both modes. This takes effect in the cycle after the strobe.
- R5: With `col_inv` low (pixel inversion), each back-porch strobe on lines 23 to 261 inverts `pol`.
- R6: With `col_inv` high (column inversion), each back-porch strobe on lines 22 to 261 sets `pol` to the base polarity, so the window holds one level.
- R7: With `quarter_rate` low, every `field_start` pulse inverts the base polarity. The base is seen on `pol` at line 22.
- R8: With `quarter_rate` high, a `field_start` pulse inverts the base polarity only when the field counter moves to an even value. The base therefore alternates every second field.
- R9: A back-porch strobe on line 4 while the field counter is even inverts `pol`, in either mode.
- R10: A change of `col_inv` between strobes has no effect on `pol` until the next back-porch strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_num | input | LINE_W | Current video line number within the field |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| back_porch | input | 1 | One-cycle strobe in the back porch of the current line |
| col_inv | input | 1 | 1 = column inversion, 0 = pixel inversion |
| quarter_rate | input | 1 | 1 = base alternates every second field, 0 = every field |
| pol | output | 1 | Panel drive polarity |

## Verification
The hardest state to reach from the ports is the quarter-rate base polarity. It is hidden, and it shows on `pol` only at line 22 of a field. It is also masked by the line-4 extra toggle and by per-line toggles everywhere else. The bench therefore plays whole fields of 262 strobed lines and keeps its own field counter and base polarity. It then compares `pol` after every strobe, across four consecutive quarter-rate fields, so that both the flipping and the non-flipping field boundaries appear. A mode change in the middle of a field, with no strobe, checks that the selects only matter at the next back porch.

// File: rtl/lcd_pol_inv.sv
module lcd_pol_inv #(
  parameter int LINE_W     = 10,
  parameter int WIN_FIRST  = 22,
  parameter int WIN_LAST   = 261,
  parameter int EXTRA_LINE = 4,
  parameter int FCNT_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_start,
  input  logic              back_porch,
  input  logic              col_inv,
  input  logic              quarter_rate,
  output logic              pol
);

  localparam logic [LINE_W-1:0] FIRST_L = LINE_W'(WIN_FIRST);
  localparam logic [LINE_W-1:0] LAST_L  = LINE_W'(WIN_LAST);
  localparam logic [LINE_W-1:0] EXTRA_L = LINE_W'(EXTRA_LINE);

  logic [FCNT_W-1:0] fcnt;
  logic              base;

  wire in_win   = (line_num >= FIRST_L) && (line_num <= LAST_L);
  wire extra    = (line_num == EXTRA_L) && !fcnt[0];
  wire flip_base = !quarter_rate || fcnt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
      base <= 1'b0;
    end else if (field_start) begin
      fcnt <= fcnt + 1'b1;
      if (flip_base) base <= ~base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol <= 1'b0;
    end else if (back_porch) begin
      if (extra)
        pol <= ~pol;
      else if (in_win) begin
        if (col_inv || line_num == FIRST_L) pol <= base;
        else                                pol <= ~pol;
      end
    end
  end

endmodule

// File: rtl/lcd_pol_inv_chk.sv
module lcd_pol_inv_chk #(
  parameter int LINE_W     = 10,
  parameter int WIN_FIRST  = 22,
  parameter int WIN_LAST   = 261,
  parameter int EXTRA_LINE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINE_W-1:0] line_num,
  input logic              field_start,
  input logic              back_porch,
  input logic              col_inv,
  input logic              quarter_rate,
  input logic              base,
  input logic              pol
);

  logic win;
  assign win = (int'(line_num) >= WIN_FIRST) && (int'(line_num) <= WIN_LAST);

  assert_pol_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !back_porch |=> $stable(pol));

  assert_outside_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (back_porch && !win && int'(line_num) != EXTRA_LINE) |=> $stable(pol));

  assert_first_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (back_porch && int'(line_num) == WIN_FIRST) |=> pol == $past(base));

  assert_pixel_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (back_porch && !col_inv && win && int'(line_num) != WIN_FIRST) |=> pol != $past(pol));

  assert_column_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (back_porch && col_inv && win) |=> pol == $past(base));

  assert_half_rate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !quarter_rate) |=> base != $past(base));

endmodule

bind lcd_pol_inv lcd_pol_inv_chk #(
  .LINE_W(LINE_W), .WIN_FIRST(WIN_FIRST), .WIN_LAST(WIN_LAST), .EXTRA_LINE(EXTRA_LINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_num(line_num), .field_start(field_start),
  .back_porch(back_porch), .col_inv(col_inv), .quarter_rate(quarter_rate),
  .base(base), .pol(pol)
);

// File: tb/lcd_pol_inv_tb.sv
module lcd_pol_inv_tb;
  localparam int LW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] line_num = '0;
  logic          field_start = 1'b0;
  logic          back_porch = 1'b0;
  logic          col_inv = 1'b0;
  logic          quarter_rate = 1'b0;
  logic          pol;

  int n_chk = 0;
  int n_bad = 0;

  int m_cnt = 0;
  logic m_base = 1'b0;
  logic m_pol = 1'b0;

  always #2 clk = ~clk;

  lcd_pol_inv u_dut (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .field_start(field_start),
    .back_porch(back_porch), .col_inv(col_inv), .quarter_rate(quarter_rate), .pol(pol)
  );

  task automatic chk(input string req, input logic exp);
    n_chk++;
    if (pol !== exp) begin
      n_bad++;
      $display("FAIL %s: pol=%b expected=%b line=%0d", req, pol, exp, line_num);
    end
  endtask

  task automatic new_field();
    field_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    field_start = 1'b0;
    m_cnt = (m_cnt + 1) % 4;
    if (!quarter_rate || (m_cnt % 2 == 0)) m_base = ~m_base;
  endtask

  task automatic strobe(input int ln);
    string tag;
    line_num = LW'(ln);
    back_porch = 1'b1;
    @(posedge clk);
    @(negedge clk);
    back_porch = 1'b0;
    if (ln == 4 && (m_cnt % 2 == 0)) begin m_pol = ~m_pol; tag = "R9"; end
    else if (ln == 22) begin
      m_pol = m_base;
      tag = col_inv ? "R4" : (quarter_rate ? "R8" : "R7");
    end
    else if (ln > 22 && ln <= 261) begin
      if (col_inv) begin m_pol = m_base; tag = "R6"; end
      else begin m_pol = ~m_pol; tag = "R5"; end
    end
    else tag = "R2";
    chk(tag, m_pol);
  endtask

  task automatic run_field();
    new_field();
    for (int l = 1; l <= 262; l++) strobe(l);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 1'b0);
  endtask

  task automatic t_no_strobe();
    for (int l = 20; l < 30; l++) begin
      line_num = LW'(l);
      col_inv = l[0];
      @(negedge clk);
      chk("R3", m_pol);
    end
    col_inv = 1'b0;
  endtask

  task automatic t_half_pixel();
    quarter_rate = 1'b0; col_inv = 1'b0;
    for (int f = 0; f < 2; f++) run_field();
  endtask

  task automatic t_quarter_pixel();
    quarter_rate = 1'b1; col_inv = 1'b0;
    for (int f = 0; f < 4; f++) run_field();
  endtask

  task automatic t_column();
    col_inv = 1'b1;
    quarter_rate = 1'b1;
    for (int f = 0; f < 2; f++) run_field();
    quarter_rate = 1'b0;
    for (int f = 0; f < 2; f++) run_field();
  endtask

  task automatic t_mode_switch();
    col_inv = 1'b0; quarter_rate = 1'b0;
    new_field();
    for (int l = 1; l <= 101; l++) strobe(l);
    col_inv = 1'b1;
    line_num = LW'(102);
    repeat (3) begin
      @(negedge clk);
      chk("R10", m_pol);
    end
    for (int l = 102; l <= 262; l++) strobe(l);
    col_inv = 1'b0;
  endtask

  initial begin
    t_reset();
    t_no_strobe();
    t_half_pixel();
    t_quarter_pixel();
    t_column();
    t_mode_switch();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule